// File: doc/BRIEF.md
# Selectable Three-Detector Phase Comparator

This block compares a reference signal with a feedback signal coming back from an oscillator or divider in an all-digital PLL. Both single-bit inputs are asynchronous to the system clock. Each input passes through a synchronizer chain of configurable depth and a rising-edge detector. After that, three independent error detectors run at the same time.

The first detector is a level-based exclusive-OR detector. The second is an edge-driven detector that drives high, drives low or releases its output. It comes with an in-lock flag that is high whenever the output is released. The third is a set/clear flop: a reference edge sets it and a feedback edge clears it.

Every detector result appears on its own output. A two-bit selector also routes one of them onto a shared loop-filter pair, made of a value bit and an enable bit. The reset input is asynchronous and active low. Its release must already be aligned to the clock by the surrounding reset logic.

Top module: `phase_cmp3`

## Requirements
- R1: While `rst_n` is low, `xor_out`, `tri_oe`, `tri_val` and `sr_out` are 0 and `lock_out` is 1.
- R2: `xor_out` equals the exclusive-OR of the two input levels. A level change seen at a clock edge reaches `xor_out` after SYNC_STAGES further rising clock edges. Inputs in phase give 0% duty; inputs half a period apart give 100% duty.
- R3: Assume the output is released. A reference rising edge with no feedback edge in the same cycle makes the edge detector drive high (`tri_oe`=1, `tri_val`=1). It keeps driving high until a feedback rising edge is detected, and then it releases (`tri_oe`=0).
- R4: Assume the output is released. A feedback rising edge with no reference edge in the same cycle makes the edge detector drive low (`tri_oe`=1, `tri_val`=0). It keeps driving low until a reference rising edge is detected, and then it releases.
- R5: `lock_out` is 1 exactly when `tri_oe` is 0.
- R6: Suppose reference and feedback rising edges are detected in the same clock cycle. Then the edge detector is released in the following cycle, and `sr_out` keeps its value.
- R7: A lone reference rising edge sets `sr_out` to 1. A lone feedback rising edge clears it to 0.
- R8: Only rising edges affect the edge detector and `sr_out`. Falling edges, pulse widths and duty cycle have no effect. A short glitch on the reference input counts as a full edge.
- R9: `mode` selects what drives `lf_val`/`lf_oe`:
  - 0 routes `xor_out` with `lf_oe`=1.
  - 1 routes `tri_val`/`tri_oe`.
  - 2 routes `sr_out` with `lf_oe`=1.
  - 3 behaves as 1.
- R10: Feedback edges that arrive with no reference edges keep the edge detector driving low. Repeated reference edges with no feedback edges keep it driving high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized externally |
| ref_in | input | 1 | Reference signal, asynchronous |
| fb_in | input | 1 | Feedback signal from oscillator or divider, asynchronous |
| mode | input | 2 | Loop-filter source select |
| xor_out | output | 1 | Exclusive-OR detector result |
| tri_oe | output | 1 | Edge detector drive enable (0 = released) |
| tri_val | output | 1 | Edge detector drive level when enabled |
| lock_out | output | 1 | High while the edge detector is released |
| sr_out | output | 1 | Set/clear detector result |
| lf_oe | output | 1 | Loop-filter drive enable for the selected detector |
| lf_val | output | 1 | Loop-filter drive level for the selected detector |

## Verification
The bench instantiates the block with SYNC_STAGES = 3 rather than the default of 2. This lengthens the input-to-output latency, so the latency check in its model cannot pass by accident with a hard-coded depth. It also exercises the generated synchronizer beyond its minimum. Directed sequences cover these cases:
- lead and lag;
- same-cycle edges;
- glitches and wide pulses;
- feedback-only and reference-only trains.

Randomized hold lengths and selector values cover the rest of the input space.

// File: rtl/phase_cmp3_pkg.sv
package phase_cmp3_pkg;
  typedef enum logic [1:0] {
    SEL_XOR  = 2'd0,
    SEL_EDGE = 2'd1,
    SEL_SR   = 2'd2,
    SEL_RSV  = 2'd3
  } lf_sel_e;
endpackage

// File: rtl/pc3_edge_sync.sv
module pc3_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              last_q, last_d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_comb chain_d[i] = din;
    end else begin : g_next
      always_comb chain_d[i] = chain_q[i-1];
    end
  end

  assign level  = chain_q[STAGES-1];
  assign last_d = level;
  assign rise   = level & ~last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= last_d;
    end
  end

  assert_rise_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/pc3_tristate_det.sv
module pc3_tristate_det (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise,
  input  logic fb_rise,
  output logic drv_oe,
  output logic drv_val,
  output logic locked
);
  logic up_q, up_d, dn_q, dn_d;
  logic want_up, want_dn;

  always_comb begin
    want_up = up_q | ref_rise;
    want_dn = dn_q | fb_rise;
    up_d    = want_up & ~want_dn;
    dn_d    = want_dn & ~want_up;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  assign drv_oe  = up_q | dn_q;
  assign drv_val = up_q;
  assign locked  = ~(up_q | dn_q);

  assert_no_dual_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_q && dn_q));
  assert_up_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && !fb_rise && !dn_q) |=> (drv_oe && drv_val));
  assert_dn_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_rise && !ref_rise && !up_q) |=> (drv_oe && !drv_val));
  assert_both_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && fb_rise) |=> locked);
  assert_up_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !fb_rise) |=> (drv_oe && drv_val));
endmodule

// File: rtl/pc3_setclr_det.sv
module pc3_setclr_det (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise,
  input  logic fb_rise,
  output logic sr_out
);
  logic sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (ref_rise && !fb_rise) sr_d = 1'b1;
    else if (fb_rise && !ref_rise) sr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 1'b0;
    else        sr_q <= sr_d;
  end

  assign sr_out = sr_q;

  assert_sr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise == fb_rise) |=> $stable(sr_out));
  assert_sr_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && !fb_rise) |=> sr_out);
  assert_sr_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_rise && !ref_rise) |=> !sr_out);
endmodule

// File: rtl/phase_cmp3.sv
module phase_cmp3
  import phase_cmp3_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_in,
  input  logic       fb_in,
  input  logic [1:0] mode,
  output logic       xor_out,
  output logic       tri_oe,
  output logic       tri_val,
  output logic       lock_out,
  output logic       sr_out,
  output logic       lf_oe,
  output logic       lf_val
);
  logic ref_lvl, ref_rise, fb_lvl, fb_rise;
  logic xor_q, xor_d;
  lf_sel_e sel;

  pc3_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
    .clk(clk), .rst_n(rst_n), .din(ref_in), .level(ref_lvl), .rise(ref_rise));
  pc3_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_sync (
    .clk(clk), .rst_n(rst_n), .din(fb_in), .level(fb_lvl), .rise(fb_rise));

  pc3_tristate_det u_edge_det (
    .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise), .fb_rise(fb_rise),
    .drv_oe(tri_oe), .drv_val(tri_val), .locked(lock_out));

  pc3_setclr_det u_sr_det (
    .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise), .fb_rise(fb_rise),
    .sr_out(sr_out));

  assign xor_d = ref_lvl ^ fb_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xor_q <= 1'b0;
    else        xor_q <= xor_d;
  end

  assign xor_out = xor_q;
  assign sel     = lf_sel_e'(mode);

  always_comb begin
    unique case (sel)
      SEL_XOR: begin lf_val = xor_q;   lf_oe = 1'b1;   end
      SEL_SR:  begin lf_val = sr_out;  lf_oe = 1'b1;   end
      default: begin lf_val = tri_val; lf_oe = tri_oe; end
    endcase
  end

  assert_lf_xor_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> (lf_oe && lf_val == xor_out));
  assert_lf_sr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> (lf_oe && lf_val == sr_out));
  assert_lf_rsv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> (lf_oe == tri_oe && lf_val == tri_val));
  assert_lock_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_out |-> (mode != 2'd1 || !lf_oe));
endmodule

// File: tb/phase_cmp3_tb.sv
module phase_cmp3_tb;
  localparam int S = 3;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0, fb_in = 1'b0;
  logic [1:0] mode = 2'd0;
  logic xor_out, tri_oe, tri_val, lock_out, sr_out, lf_oe, lf_val;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [S-1:0] mr, mf;
  logic mrp, mfp, mx, mu, md, ms;

  always #4 clk = ~clk;

  phase_cmp3 #(.SYNC_STAGES(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in), .mode(mode),
    .xor_out(xor_out), .tri_oe(tri_oe), .tri_val(tri_val), .lock_out(lock_out),
    .sr_out(sr_out), .lf_oe(lf_oe), .lf_val(lf_val));

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_lf_val();
    case (mode)
      2'd0: return mx;
      2'd2: return ms;
      default: return mu;
    endcase
  endfunction

  function automatic logic exp_lf_oe();
    return (mode == 2'd0 || mode == 2'd2) ? 1'b1 : (mu | md);
  endfunction

  task automatic compare_all(input string scen);
    chk({scen, " R2 xor"}, xor_out, mx);
    chk({scen, " R3 R4 oe"}, tri_oe, mu | md);
    chk({scen, " R3 R4 val"}, tri_val, mu);
    chk({scen, " R5 lock"}, lock_out, ~(mu | md));
    chk({scen, " R7 sr"}, sr_out, ms);
    chk({scen, " R9 lf_val"}, lf_val, exp_lf_val());
    chk({scen, " R9 lf_oe"}, lf_oe, exp_lf_oe());
  endtask

  // expected behaviour over one rising clock edge, from the requirements
  task automatic model_edge(input logic r, input logic f);
    logic rr, fr, wu, wd;
    rr = mr[S-1] & ~mrp;
    fr = mf[S-1] & ~mfp;
    mx = mr[S-1] ^ mf[S-1];
    wu = mu | rr;
    wd = md | fr;
    mu = wu & ~wd;
    md = wd & ~wu;
    if (rr && !fr) ms = 1'b1;
    else if (fr && !rr) ms = 1'b0;
    mrp = mr[S-1];
    mfp = mf[S-1];
    mr = {mr[S-2:0], r};
    mf = {mf[S-2:0], f};
  endtask

  task automatic step(input string scen, input logic r, input logic f, input logic [1:0] m);
    @(negedge clk);
    compare_all(scen);
    ref_in = r;
    fb_in  = f;
    mode   = m;
    model_edge(r, f);
  endtask

  task automatic hold(input string scen, input logic r, input logic f, input int n,
                      input logic [1:0] m);
    for (int i = 0; i < n; i++) step(scen, r, f, m);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    mr = '0; mf = '0; mrp = 0; mfp = 0; mx = 0; mu = 0; md = 0; ms = 0;
    repeat (3) @(negedge clk);
    chk("R1 xor", xor_out, 1'b0);
    chk("R1 oe", tri_oe, 1'b0);
    chk("R1 val", tri_val, 1'b0);
    chk("R1 lock", lock_out, 1'b1);
    chk("R1 sr", sr_out, 1'b0);
    rst_n = 1'b1;
    // R3: reference leads, feedback follows
    hold("R3", 0, 0, 6, 2'd1);
    hold("R3", 1, 0, 6, 2'd1);
    hold("R3", 1, 1, 8, 2'd1);
    hold("R3", 0, 0, 6, 2'd1);
    // R4: feedback leads
    hold("R4", 0, 1, 6, 2'd3);
    hold("R4", 1, 1, 8, 2'd3);
    hold("R4", 0, 0, 6, 2'd3);
    // R6: edges together
    hold("R6", 1, 1, 8, 2'd2);
    hold("R6", 0, 0, 6, 2'd2);
    // R8: one-cycle glitch counts as an edge; wide pulse same as narrow
    step("R8", 1, 0, 2'd1);
    hold("R8", 0, 0, 8, 2'd1);
    hold("R8", 0, 1, 20, 2'd1);
    hold("R8", 0, 0, 6, 2'd1);
    // R10: feedback-only train, then reference-only train
    for (int k = 0; k < 6; k++) begin
      hold("R10", 0, 1, 3, 2'd1);
      hold("R10", 0, 0, 3, 2'd1);
    end
    for (int k = 0; k < 6; k++) begin
      hold("R10", 1, 0, 2, 2'd2);
      hold("R10", 0, 0, 4, 2'd2);
    end
    // R2: quadrature and anti-phase square waves through the XOR path
    for (int k = 0; k < 8; k++) begin
      hold("R2", 1, 0, 2, 2'd0);
      hold("R2", 1, 1, 2, 2'd0);
      hold("R2", 0, 1, 2, 2'd0);
      hold("R2", 0, 0, 2, 2'd0);
    end
    for (int k = 0; k < 6; k++) begin
      hold("R2", 1, 0, 4, 2'd0);
      hold("R2", 0, 1, 4, 2'd0);
    end
    // random mix, all selector values (R9)
    for (int k = 0; k < 3000; k++) begin
      logic r, f;
      logic [1:0] m;
      int n;
      r = 1'($urandom);
      f = 1'($urandom);
      m = 2'($urandom);
      n = 1 + ($urandom % 6);
      hold("R9 random", r, f, n, m);
    end
    hold("R9 drain", 0, 0, 8, 2'd0);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule